// File: doc/BRIEF.md
# Speech Byte Buffer with Threshold Interrupts

This block is a sixteen-entry byte queue placed between a host that writes command or speech bytes through a parallel port and a frame consumer that pulls them at its own pace. Bytes leave in the order they arrived. The block tracks how many bytes it holds and derives three conditions from that count and from the consumer's busy line. The buffer is low when it holds one to eight bytes. It is empty when it holds none. Talking is done when it is empty and the consumer is no longer busy.

The host sees these conditions, and a sticky overflow bit, in a status byte that is always driven. A one-cycle read strobe tells the block that the host has taken the status. An interrupt line asks the host for more data whenever the queue drops into a low or drained state. While the queue is full, a ready line tells the host to hold off.

Top module: `speech_fifo`

## Requirements
- R1: The buffer stores up to 16 bytes and returns them in arrival order. A pop with `rd_en` high and the buffer not empty places the oldest byte on `rd_data` at the next clock edge. `rd_data` holds its value when `rd_en` is low.
- R2: Status bit 1 (low) is 1 exactly when occupancy is between 1 and 8 inclusive.
- R3: Status bit 0 (empty) is 1 exactly when occupancy is 0.
- R4: Status bit 2 (talk done) is 1 when occupancy is 0 and `talk_busy` was low at the previous clock edge.
- R5: `irq` rises in the cycle after any of these events: entry into low, entry into empty, entry into talk done, or an accepted write that leaves occupancy between 1 and 8. `irq` is never 1 while occupancy is above 8.
- R6: `wr_ready` is 0 exactly while occupancy is 16.
- R7: Pulsing `stat_rd` changes neither the stored bytes nor the occupancy.
- R8: A `stat_rd` pulse clears a pending `irq` and the overflow bit, unless a new event or an overflow write happens in the same cycle.
- R9: A write while the buffer is full is dropped, and it sets status bit 3 (overflow), which stays set until a status read.
- R10: A pop from an empty buffer puts 0 on `rd_data` and leaves occupancy unchanged. A write in the same cycle is still stored.
- R11: After reset the buffer is empty, `status` reads 0x05, `irq` is 0, `wr_ready` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to store |
| wr_ready | output | 1 | Buffer can accept a byte |
| rd_en | input | 1 | Consumer pop strobe |
| rd_data | output | 8 | Popped byte, registered |
| talk_busy | input | 1 | Consumer is still producing speech |
| stat_rd | input | 1 | Host status read strobe; clears irq and overflow |
| status | output | 8 | {4'b0, overflow, talk done, low, empty} |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest states to reach are the crossings of the half-full mark in both directions, combined with a status read in the same cycle. These are a pop from nine to eight while the host clears the interrupt, and a write that pushes occupancy from eight to nine while an interrupt is pending. Random traffic with a write bias close to the pop bias keeps occupancy drifting around eight. Status reads fire often enough to collide with those crossings. Directed passes fill the buffer one byte at a time with a read after every write, overrun it, drain it past empty, and drop `talk_busy` while the buffer is empty.

// File: rtl/speech_fifo.sv
module speech_fifo #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          talk_busy,
  input  logic          stat_rd,
  output logic [7:0]    status,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] LOWC  = CW'(LOW_MARK);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, count_n;
  logic          busy_q, ovf, irq_q;

  wire push = wr_en && (count != FULLC);
  wire pop  = rd_en && (count != '0);

  assign count_n = count + CW'(push) - CW'(pop);

  wire empty   = (count == '0);
  wire low     = !empty && (count <= LOWC);
  wire done    = empty && !busy_q;
  wire empty_n = (count_n == '0);
  wire low_n   = !empty_n && (count_n <= LOWC);
  wire done_n  = empty_n && !talk_busy;

  wire event_hit = (low_n && !low) || (empty_n && !empty) ||
                   (done_n && !done) || (push && low_n);

  assign wr_ready = (count != FULLC);
  assign status   = {4'b0, ovf, done, low, empty};
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      rd_data <= '0;
      busy_q  <= 1'b0;
      ovf     <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (rd_en) rd_data <= pop ? mem[rp] : '0;
      count  <= count_n;
      busy_q <= talk_busy;
      ovf    <= (wr_en && !wr_ready) || (ovf && !stat_rd);
      irq_q  <= (count_n <= LOWC) && ((irq_q && !stat_rd) || event_hit);
    end
  end

  // R1
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count > LOWC) |-> !irq);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready && !rd_en) |=> ($stable(count) && ovf));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && empty) |=> (rd_data == '0 && count == '0));

  // R7
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wr_en && !rd_en) |=> $stable(count));

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(wr_en && !wr_ready)) |=> !ovf);
endmodule

// File: tb/sim_speech_fifo.sv
module sim_speech_fifo;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, talk_busy = 0, stat_rd = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, irq;
  logic [7:0] rd_data, status;

  speech_fifo u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .talk_busy(talk_busy),
    .stat_rd(stat_rd), .status(status), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic irqx = 0, ovfx = 0, bq = 0;
  logic [7:0] rdx = 0;
  string rdtag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_low(int n);
    return n >= 1 && n <= 8;
  endfunction

  function automatic logic [7:0] exp_status(int n, logic b, logic o);
    return {4'b0, o, (n == 0) && !b, in_low(n), n == 0};
  endfunction

  task automatic compare();
    logic [7:0] es;
    es = exp_status(q.size(), bq, ovfx);
    chk(status[0] == es[0], "R3", status, es);
    chk(status[1] == es[1], "R2", status, es);
    chk(status[2] == es[2], "R4", status, es);
    chk(status[3] == es[3], "R9", status, es);
    chk(status[7:4] == 0, "R2", status, es);
    chk(irq == irqx, "R5", irq, irqx);
    chk(wr_ready == (q.size() != 16), "R6", wr_ready, q.size() != 16);
    chk(rd_data == rdx, rdtag, rd_data, rdx);
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic s, input logic b);
    int n0, n1;
    bit full, pushm, popm, ev;
    wr_en = w; wr_data = d; rd_en = r; stat_rd = s; talk_busy = b;
    @(posedge clk);
    n0 = q.size();
    full = (n0 == 16);
    pushm = w && !full;
    popm = r && (n0 != 0);
    if (r) begin
      rdx = popm ? q.pop_front() : 8'h00;
      rdtag = popm ? "R1" : "R10";
    end
    if (pushm) q.push_back(d);
    n1 = q.size();
    ev = (in_low(n1) && !in_low(n0)) || (n1 == 0 && n0 != 0) ||
         ((n1 == 0 && !b) && !(n0 == 0 && !bq)) || (pushm && in_low(n1));
    irqx = (n1 <= 8) && ((irqx && !s) || ev);
    ovfx = (w && full) || (ovfx && !s);
    bq = b;
    @(negedge clk);
    wr_en = 0; rd_en = 0; stat_rd = 0;
    compare();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(status == 8'h05, "R11", status, 8'h05);
    chk(irq == 0, "R11", irq, 0);
    chk(wr_ready == 1, "R11", wr_ready, 1);
    chk(rd_data == 0, "R11", rd_data, 0);

    // R5 per-write interrupt up to eighth byte, none at ninth; R8 clear on read
    for (int i = 1; i <= 9; i++) begin
      step(1, 8'(i * 17), 0, 0, 0);
      chk(irq == (i <= 8), "R5", irq, i <= 8);
      step(0, 0, 0, 1, 0);
      chk(irq == 0, "R8", irq, 0);
    end
    for (int i = 10; i <= 16; i++) step(1, 8'(i * 17), 0, 0, 0);
    chk(wr_ready == 0, "R6", wr_ready, 0);
    // R9 overrun
    step(1, 8'hEE, 0, 0, 0);
    chk(status[3] == 1, "R9", status, 1);
    step(0, 0, 0, 0, 0);
    chk(status[3] == 1, "R9", status, 1);
    // R7 / R8 status read leaves contents alone
    step(0, 0, 0, 1, 0);
    chk(status[3] == 0, "R8", status, 0);
    chk(wr_ready == 0, "R7", wr_ready, 0);
    // drain in order, one past empty (R1, R10)
    for (int i = 1; i <= 16; i++) begin
      step(0, 0, 1, 0, 0);
      chk(rd_data == 8'(i * 17), "R1", rd_data, 8'(i * 17));
    end
    step(0, 0, 1, 0, 0);
    chk(rd_data == 0, "R10", rd_data, 0);
    chk(status[0] == 1, "R10", status, 1);
    step(1, 8'h5A, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    chk(rd_data == 8'h5A, "R10", rd_data, 8'h5A);
    // R4 end of talk
    step(0, 0, 0, 1, 1);
    chk(status[2] == 0, "R4", status, 0);
    step(0, 0, 0, 0, 0);
    chk(status[2] == 1 && irq == 1, "R4", {status[2], irq}, 3);

    for (int k = 0; k < 4000; k++) begin
      logic w, r, s, b;
      w = ($urandom % 100) < 50;
      r = ($urandom % 100) < 45;
      s = ($urandom % 100) < 20;
      b = (($urandom % 100) < 10) ? !bq : bq;
      step(w, 8'($urandom), r, s, b);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule